// File: doc/BRIEF.md
# Complementary Output Deadtime Stage

This stage turns one channel reference level into a pair of pin levels for a half-bridge: a main output that follows the reference and a complementary output that follows its inverse. Whenever the reference changes, the output that has to turn off does so at once. The output that has to turn on waits a programmable number of clock cycles, so that the external switch being released has time to stop conducting before its partner starts. The same wait is applied to every edge.

Each pin has its own polarity bit and its own enable bit. A master enable selects between running and idle. When the master enable drops, both pins first go to their inactive levels for the deadtime. After that each pin settles to its own programmed idle level. When the master enable returns, the pins follow the running logic again on the next cycle.

All control inputs are plain static levels. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `cmpl_deadtime`

## Requirements
- R1: After reset the stage is idle: the main pin shows `idle_main_i` and the complementary pin shows `idle_comp_i`. The internal reference is taken as low.
- R2: When the sampled reference goes from 0 to 1, the complementary output becomes inactive on the cycle after the clock edge that samples the change. The main output becomes active `dt_i` cycles later than that.
- R3: When the sampled reference goes from 1 to 0, the same timing applies with the roles swapped: the main output drops at once and the complementary output turns on `dt_i` cycles later.
- R4: With `dt_i` = 0 the two outputs switch on the same edge, with no cycle where both are inactive.
- R5: If the reference changes back before the deadtime of the previous edge has run out, the output that was waiting never becomes active. The count restarts from the new edge.
- R6: In running mode an enabled pin equals its active state XOR its polarity bit. Polarity 0 means active-high and polarity 1 means active-low.
- R7: In running mode, a pin whose enable bit is 0 sits at its inactive level, which is equal to its polarity bit.
- R8: When `moe_i` is sampled low while running, both pins are at their inactive levels for `dt_i` cycles. After that they show their idle-level bits. While idle, the enable bits have no effect.
- R9: When `moe_i` is sampled high, the pins show the running-mode levels from the next cycle on. No extra deadtime is added at this point.
- R10: The deadtime used for an edge is the `dt_i` value sampled on that edge. Later changes to `dt_i` do not alter a count that is already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Channel reference level |
| dt_i | input | DT_W | Deadtime in clock cycles |
| pol_main_i | input | 1 | Main pin polarity (1 = active-low) |
| pol_comp_i | input | 1 | Complementary pin polarity (1 = active-low) |
| en_main_i | input | 1 | Main pin enable |
| en_comp_i | input | 1 | Complementary pin enable |
| moe_i | input | 1 | Master output enable |
| idle_main_i | input | 1 | Main pin level when idle |
| idle_comp_i | input | 1 | Complementary pin level when idle |
| out_main_o | output | 1 | Main pin |
| out_comp_o | output | 1 | Complementary pin |

## Verification
A change of reference or master enable takes effect at the next rising edge. The pins show its effect from that cycle on. An output that is turning on, or the move to idle levels, follows `dt_i` edges after that. Polarity, enable and idle-level bits act on the pins within the same cycle.

The bench drives inputs just after a falling edge and advances its own model at the rising edge. It compares both pins at the following falling edge, once every cycle. In the model, each pending turn-on is a count of edges since the event that started it, checked against the deadtime latched at that event.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_IDLE_DT = 2'd1,
    MODE_IDLE    = 2'd2
  } cdt_mode_e;
endpackage

// File: rtl/cdt_edge_timer.sv
module cdt_edge_timer #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            ref_q_o,
  output logic [DT_W-1:0] cnt_o,
  output logic            main_on_o,
  output logic            comp_on_o
);
  localparam logic [DT_W-1:0] CNT_ONE  = {{(DT_W-1){1'b0}}, 1'b1};
  localparam logic [DT_W-1:0] CNT_ZERO = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q_o   <= 1'b0;
      cnt_o     <= CNT_ZERO;
      main_on_o <= 1'b0;
      comp_on_o <= 1'b1;
    end else if (ref_i != ref_q_o) begin
      // new edge: release the active side now, restart the wait
      ref_q_o <= ref_i;
      cnt_o   <= dt_i;
      if (dt_i == CNT_ZERO) begin
        main_on_o <= ref_i;
        comp_on_o <= ~ref_i;
      end else begin
        main_on_o <= 1'b0;
        comp_on_o <= 1'b0;
      end
    end else if (cnt_o != CNT_ZERO) begin
      cnt_o <= cnt_o - CNT_ONE;
      if (cnt_o == CNT_ONE) begin
        main_on_o <= ref_q_o;
        comp_on_o <= ~ref_q_o;
      end
    end
  end
endmodule

// File: rtl/cdt_idle_ctrl.sv
module cdt_idle_ctrl
  import cdt_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            moe_i,
  input  logic [DT_W-1:0] dt_i,
  output cdt_mode_e       mode_o
);
  localparam logic [DT_W-1:0] CNT_ONE  = {{(DT_W-1){1'b0}}, 1'b1};
  localparam logic [DT_W-1:0] CNT_ZERO = '0;

  logic [DT_W-1:0] icnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= MODE_IDLE;
      icnt   <= CNT_ZERO;
    end else begin
      unique case (mode_o)
        MODE_RUN: begin
          if (!moe_i) begin
            icnt   <= dt_i;
            mode_o <= (dt_i == CNT_ZERO) ? MODE_IDLE : MODE_IDLE_DT;
          end
        end
        MODE_IDLE_DT: begin
          if (moe_i) begin
            mode_o <= MODE_RUN;
            icnt   <= CNT_ZERO;
          end else if (icnt == CNT_ONE) begin
            mode_o <= MODE_IDLE;
            icnt   <= CNT_ZERO;
          end else begin
            icnt <= icnt - CNT_ONE;
          end
        end
        default: begin
          if (moe_i) mode_o <= MODE_RUN;
        end
      endcase
    end
  end
endmodule

// File: rtl/cdt_pin_drive.sv
module cdt_pin_drive
  import cdt_pkg::*;
(
  input  logic      active_i,
  input  logic      pol_i,
  input  logic      en_i,
  input  logic      idle_lvl_i,
  input  cdt_mode_e mode_i,
  output logic      pin_o
);
  always_comb begin
    unique case (mode_i)
      MODE_RUN:     pin_o = en_i ? (active_i ^ pol_i) : pol_i;
      MODE_IDLE_DT: pin_o = pol_i;
      default:      pin_o = idle_lvl_i;
    endcase
  end
endmodule

// File: rtl/cmpl_deadtime.sv
module cmpl_deadtime
  import cdt_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dt_i,
  input  logic            pol_main_i,
  input  logic            pol_comp_i,
  input  logic            en_main_i,
  input  logic            en_comp_i,
  input  logic            moe_i,
  input  logic            idle_main_i,
  input  logic            idle_comp_i,
  output logic            out_main_o,
  output logic            out_comp_o
);
  localparam int NPIN = 2;

  logic            ref_q;
  logic [DT_W-1:0] dt_cnt;
  logic            main_on;
  logic            comp_on;
  cdt_mode_e       mode;

  logic [NPIN-1:0] act_v, pol_v, en_v, idle_v, pin_v;

  cdt_edge_timer #(.DT_W(DT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_i     (ref_i),
    .dt_i      (dt_i),
    .ref_q_o   (ref_q),
    .cnt_o     (dt_cnt),
    .main_on_o (main_on),
    .comp_on_o (comp_on)
  );

  cdt_idle_ctrl #(.DT_W(DT_W)) u_idle (
    .clk    (clk),
    .rst_n  (rst_n),
    .moe_i  (moe_i),
    .dt_i   (dt_i),
    .mode_o (mode)
  );

  assign act_v  = {comp_on, main_on};
  assign pol_v  = {pol_comp_i, pol_main_i};
  assign en_v   = {en_comp_i, en_main_i};
  assign idle_v = {idle_comp_i, idle_main_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    cdt_pin_drive u_drv (
      .active_i   (act_v[g]),
      .pol_i      (pol_v[g]),
      .en_i       (en_v[g]),
      .idle_lvl_i (idle_v[g]),
      .mode_i     (mode),
      .pin_o      (pin_v[g])
    );
  end

  assign out_main_o = pin_v[0];
  assign out_comp_o = pin_v[1];
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker
  import cdt_pkg::*;
#(
  parameter int DT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ref_i,
  input logic [DT_W-1:0] dt_i,
  input logic            pol_main_i,
  input logic            pol_comp_i,
  input logic            en_main_i,
  input logic            en_comp_i,
  input logic            moe_i,
  input logic            idle_main_i,
  input logic            idle_comp_i,
  input logic            out_main_o,
  input logic            out_comp_o,
  input logic            ref_q,
  input logic [DT_W-1:0] dt_cnt,
  input logic            main_on,
  input logic            comp_on,
  input cdt_mode_e       mode
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN) |-> !((out_main_o != pol_main_i) && (out_comp_o != pol_comp_i))); // R2

  AST_MAIN_FOLLOWS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN && en_main_i && out_main_o != pol_main_i) |-> ref_q); // R3

  AST_WAIT_BOTH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_cnt != '0) |-> (!main_on && !comp_on)); // R5

  AST_DT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ref_i) != $past(ref_q)) |-> (dt_cnt == $past(dt_i))); // R10

  AST_ZERO_DT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ref_i) != $past(ref_q) && $past(dt_i) == '0)
      |-> (main_on == ref_q && comp_on == !ref_q)); // R4

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN && !moe_i && dt_i == '0)
      |=> (out_main_o == idle_main_i && out_comp_o == idle_comp_i)); // R8

  AST_RUN_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(moe_i)) |-> (mode == MODE_RUN)); // R9
endmodule

bind cmpl_deadtime cdt_checker #(.DT_W(DT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_i       (ref_i),
  .dt_i        (dt_i),
  .pol_main_i  (pol_main_i),
  .pol_comp_i  (pol_comp_i),
  .en_main_i   (en_main_i),
  .en_comp_i   (en_comp_i),
  .moe_i       (moe_i),
  .idle_main_i (idle_main_i),
  .idle_comp_i (idle_comp_i),
  .out_main_o  (out_main_o),
  .out_comp_o  (out_comp_o),
  .ref_q       (ref_q),
  .dt_cnt      (dt_cnt),
  .main_on     (main_on),
  .comp_on     (comp_on),
  .mode        (mode)
);

// File: tb/cmpl_deadtime_tb.sv
`timescale 1ns/1ps
module cmpl_deadtime_tb;
  localparam int DT_W = 8;
  localparam int BIG  = 1000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_s = 1'b0;
  logic [DT_W-1:0] dt = '0;
  logic pol_m = 1'b0, pol_c = 1'b0, en_m = 1'b1, en_c = 1'b1;
  logic moe = 1'b0, idl_m = 1'b1, idl_c = 1'b0;
  logic out_m, out_c;

  int n_chk = 0;
  int n_fail = 0;

  // bench model state
  logic m_lvl;
  int   m_since, m_dt;
  logic m_run;
  int   m_isince, m_idt;

  always #2.5 clk = ~clk;

  cmpl_deadtime #(.DT_W(DT_W)) u_dut (
    .clk (clk), .rst_n (rst_n), .ref_i (ref_s), .dt_i (dt),
    .pol_main_i (pol_m), .pol_comp_i (pol_c),
    .en_main_i (en_m), .en_comp_i (en_c), .moe_i (moe),
    .idle_main_i (idl_m), .idle_comp_i (idl_c),
    .out_main_o (out_m), .out_comp_o (out_c)
  );

  function automatic logic exp_pin(input logic act, input logic pol,
                                   input logic en, input logic idl);
    if (m_run) return en ? (act ^ pol) : pol;
    if (m_isince < m_idt) return pol;
    return idl;
  endfunction

  function automatic string auto_tag();
    if (!m_run) return "R8";
    if (!en_m || !en_c) return "R7";
    if (m_dt == 0) return "R4";
    if (m_since < m_dt) return m_lvl ? "R2" : "R3";
    return "R6";
  endfunction

  task automatic model_reset();
    m_lvl = 1'b0; m_since = BIG; m_dt = 0;
    m_run = 1'b0; m_isince = BIG; m_idt = 0;
  endtask

  task automatic model_edge();
    if (ref_s != m_lvl) begin
      m_lvl = ref_s; m_since = 0; m_dt = int'(dt);
    end else if (m_since < BIG) m_since++;
    if (moe) m_run = 1'b1;
    else if (m_run) begin
      m_run = 1'b0; m_isince = 0; m_idt = int'(dt);
    end else if (m_isince < BIG) m_isince++;
  endtask

  task automatic check_pins(input string tag);
    logic em, ec;
    string t;
    t  = (tag == "") ? auto_tag() : tag;
    em = exp_pin(m_lvl && (m_since >= m_dt), pol_m, en_m, idl_m);
    ec = exp_pin(!m_lvl && (m_since >= m_dt), pol_c, en_c, idl_c);
    n_chk += 2;
    if (out_m !== em) begin
      n_fail++;
      $display("FAIL %s main pin: actual %b expected %b at %0t", t, out_m, em, $time);
    end
    if (out_c !== ec) begin
      n_fail++;
      $display("FAIL %s comp pin: actual %b expected %b at %0t", t, out_c, ec, $time);
    end
  endtask

  // one clock: model advances at posedge, pins compared at next negedge
  task automatic cyc(input string tag, input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_pins(tag);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1957));
    model_reset();
    repeat (3) @(negedge clk);
    check_pins("R1");
    rst_n = 1'b1;
    cyc("R1", 3);

    // start running with deadtime 4
    dt = 8'd4; moe = 1'b1;
    cyc("R9", 6);
    ref_s = 1'b1; cyc("R2", 10);
    ref_s = 1'b0; cyc("R3", 10);
    // zero deadtime
    dt = 8'd0;
    ref_s = 1'b1; cyc("R4", 3);
    ref_s = 1'b0; cyc("R4", 3);
    ref_s = 1'b1; cyc("R4", 1);
    ref_s = 1'b0; cyc("R4", 4);
    // pulse shorter than deadtime
    dt = 8'd6;
    ref_s = 1'b1; cyc("R5", 3);
    ref_s = 1'b0; cyc("R5", 10);
    // deadtime changed during a count
    dt = 8'd5; ref_s = 1'b1; cyc("R10", 1);
    dt = 8'd1; cyc("R10", 8);
    // polarity
    pol_m = 1'b1; pol_c = 1'b1; cyc("R6", 2);
    ref_s = 1'b0; cyc("R6", 4);
    pol_c = 1'b0; ref_s = 1'b1; cyc("R6", 4);
    // enables off
    en_m = 1'b0; cyc("R7", 3);
    ref_s = 1'b0; en_c = 1'b0; en_m = 1'b1; cyc("R7", 4);
    en_c = 1'b1; pol_m = 1'b0;
    // master enable off with deadtime 3, then idle ignores enables
    dt = 8'd3; ref_s = 1'b1; cyc("", 5);
    moe = 1'b0; idl_m = 1'b0; idl_c = 1'b1; cyc("R8", 5);
    en_m = 1'b0; cyc("R8", 2); en_m = 1'b1;
    moe = 1'b1; cyc("R9", 3);
    dt = 8'd0; moe = 1'b0; cyc("R8", 3);
    moe = 1'b1; cyc("R9", 2);

    // constrained random phase
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 5) == 0) ref_s = ~ref_s;
      if ($urandom_range(0, 60) == 0) dt = DT_W'($urandom_range(0, 12));
      if ($urandom_range(0, 80) == 0) moe = ~moe;
      if ($urandom_range(0, 50) == 0) begin
        pol_m = 1'($urandom); pol_c = 1'($urandom);
        en_m = ($urandom_range(0, 3) != 0); en_c = ($urandom_range(0, 3) != 0);
        idl_m = 1'($urandom); idl_c = 1'($urandom);
      end
      cyc("", 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule